// File: doc/BRIEF.md
# CPU Bus Slave Port with Bus-Style Detection

This block is the processor-facing slave port of a switching core. A processor reaches the core's control registers and its two memories through it: the connection memory and the received-data memory. The port serves two kinds of bus. One is a split bus with its own 8-bit address lines and a 16-bit data bus. The other is a shared bus that carries the address on the low data byte, marked by an address-latch pulse.

A mode pin chooses split or shared operation. On a shared bus, the port detects the bus style by itself. It samples the read/data-strobe line at the rising edge of the address-latch pulse. A low level there selects separate active-low read and write strobes. A high level selects an active-high data strobe with a read/write direction line. No glue logic is needed between the port and either style of processor.

The port decodes each access into a one-cycle read or write strobe for the register file, the connection memory or the data memory. It returns read data on the data bus and answers every access with an active-low acknowledge. At the end of the access, the acknowledge is first driven high for one cycle and then released.

Top module: `cpu_port`

## Requirements
- R1: While `rst_n` is low, `ack_n_o` is 1, `ack_oe_o` and `dat_oe_o` are 0, and all five access strobes are 0.
- R2: With `mux_mode_i` = 0, the address comes from `addr_i`. An access is active while `cs_n_i` = 0 and `ds_rd_i` = 0. It is a write when `rw_wr_i` = 0 and a read when `rw_wr_i` = 1.
- R3: With `mux_mode_i` = 1, the address is taken from `dat_i[7:0]` at the rising edge of `ale_i`. If `ds_rd_i` is 0 at that edge, the port uses split strobes: `ds_rd_i` = 0 means read and `rw_wr_i` = 0 means write, both qualified by `cs_n_i` = 0.
- R4: If `ds_rd_i` is 1 at the `ale_i` rising edge, the port uses an active-high data strobe on `ds_rd_i`, qualified by `cs_n_i` = 0. The direction line `rw_wr_i` is 0 for write and 1 for read.
- R5: Address bit 7 = 0 selects register space. The register strobes are used and `acc_addr_o` carries address bits 6:0.
- R6: Address bit 7 = 1 selects memory space. `msel_i` = 0 routes the access to the connection memory and `msel_i` = 1 routes it to the data memory.
- R7: A write to the data memory, or to the frame alignment register (register address 2), produces no write strobe. It is still acknowledged.
- R8: `ack_n_o` falls after the third rising clock edge at which chip select and strobe are sampled active together. It stays low while both stay active.
- R9: After the access is released, `ack_n_o` is driven high with `ack_oe_o` = 1 for one cycle. Then `ack_oe_o` goes to 0.
- R10: A read strobe is issued one cycle after the access is first sampled. The addressed source returns data in the following cycle. The port drives that data on `dat_o` with `dat_oe_o` = 1 while the acknowledge is low.
- R11: Every strobe lasts exactly one cycle and at most one strobe is active at a time. A write strobe coincides with the acknowledge falling, and `wdata_o` then carries the sampled bus data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low reset |
| mux_mode_i | input | 1 | 1 = shared address/data bus, 0 = split bus |
| cs_n_i | input | 1 | Active-low chip select |
| ale_i | input | 1 | Address strobe / latch enable (shared bus) |
| ds_rd_i | input | 1 | Data strobe or read strobe |
| rw_wr_i | input | 1 | Read/write direction or write strobe |
| addr_i | input | 8 | Address lines (split bus) |
| dat_i | input | 16 | Bus data in; low byte carries the address on a shared bus |
| msel_i | input | 1 | Memory select from the control register: 0 connection, 1 data |
| reg_rdata_i | input | 16 | Register read data |
| cm_rdata_i | input | 16 | Connection memory read data |
| dm_rdata_i | input | 16 | Data memory read data |
| dat_o | output | 16 | Read data to the bus |
| dat_oe_o | output | 1 | Bus data drive enable |
| ack_n_o | output | 1 | Active-low transfer acknowledge |
| ack_oe_o | output | 1 | Acknowledge drive enable |
| reg_wr_o | output | 1 | Register write strobe |
| reg_rd_o | output | 1 | Register read strobe |
| cm_wr_o | output | 1 | Connection memory write strobe |
| cm_rd_o | output | 1 | Connection memory read strobe |
| dm_rd_o | output | 1 | Data memory read strobe |
| acc_addr_o | output | 7 | Location address within the selected space |
| wdata_o | output | 16 | Write data |

## Verification
The interaction to watch is a new address-latch pulse that rises in the same cycle as the previous access is released. The acknowledge is then being driven high while the next bus style and address are being captured. The bench provokes this by raising the latch pulse on the same edge that ends one shared-bus access, using the opposite strobe level from that access. It then runs the next access without a further latch phase. The check passes only if the released acknowledge is still driven high for exactly one cycle and then parked, and if the following access returns the data for the newly latched address under the newly detected style.

// File: rtl/cpu_port_pkg.sv
package cpu_port_pkg;

   // Bus flavour seen by the front end
   typedef enum logic [1:0] {
      BUS_DIRECT = 2'd0,   // split address/data, active-low strobe
      BUS_SPLIT  = 2'd1,   // shared bus, separate active-low read/write
      BUS_STROBE = 2'd2    // shared bus, active-high strobe plus direction
   } bus_style_t;

   // Destination of an access
   typedef enum logic [1:0] {
      TGT_REG  = 2'd0,
      TGT_CONN = 2'd1,
      TGT_DATA = 2'd2
   } tgt_t;

endpackage

// File: rtl/cpu_port_front.sv
module cpu_port_front
   import cpu_port_pkg::*;
#(
   parameter int AW      = 8,
   parameter int DW      = 16,
   parameter bit HAS_MUX = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          mux_mode_i,
   input  logic          cs_n_i,
   input  logic          ale_i,
   input  logic          ds_rd_i,
   input  logic          rw_wr_i,
   input  logic [AW-1:0] addr_i,
   input  logic [DW-1:0] dat_i,
   output logic          act_o,
   output logic          wr_o,
   output logic [AW-1:0] addr_o,
   output logic [DW-1:0] wdat_o,
   output bus_style_t    style_o
);

   // one sampling stage on every bus input
   logic          s_mux, s_cs_n, s_ds_rd, s_rw_wr;
   logic [AW-1:0] s_addr;
   logic [DW-1:0] s_dat;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s_mux   <= 1'b0;
         s_cs_n  <= 1'b1;
         s_ds_rd <= 1'b1;
         s_rw_wr <= 1'b1;
         s_addr  <= '0;
         s_dat   <= '0;
      end else begin
         s_mux   <= mux_mode_i;
         s_cs_n  <= cs_n_i;
         s_ds_rd <= ds_rd_i;
         s_rw_wr <= rw_wr_i;
         s_addr  <= addr_i;
         s_dat   <= dat_i;
      end
   end

   logic          mux_on;
   bus_style_t    mux_style;
   logic [AW-1:0] mux_addr;

   generate
      if (HAS_MUX) begin : g_mux
         logic          s_ale, s_ale_d;
         logic [AW-1:0] lat_addr;
         bus_style_t    lat_style;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               s_ale     <= 1'b0;
               s_ale_d   <= 1'b0;
               lat_addr  <= '0;
               lat_style <= BUS_STROBE;
            end else begin
               s_ale   <= ale_i;
               s_ale_d <= s_ale;
               if (s_ale && !s_ale_d) begin
                  lat_addr  <= s_dat[AW-1:0];
                  lat_style <= s_ds_rd ? BUS_STROBE : BUS_SPLIT;
               end
            end
         end

         assign mux_on    = s_mux;
         assign mux_style = lat_style;
         assign mux_addr  = lat_addr;
      end else begin : g_direct
         assign mux_on    = 1'b0;
         assign mux_style = BUS_DIRECT;
         assign mux_addr  = '0;
      end
   endgenerate

   bus_style_t cur_style;
   logic       strobe;
   logic       is_wr;

   assign cur_style = mux_on ? mux_style : BUS_DIRECT;

   always_comb begin
      strobe = 1'b0;
      is_wr  = 1'b0;
      case (cur_style)
         BUS_DIRECT: begin
            strobe = !s_ds_rd;
            is_wr  = !s_rw_wr;
         end
         BUS_SPLIT: begin
            strobe = !s_ds_rd || !s_rw_wr;
            is_wr  = !s_rw_wr;
         end
         BUS_STROBE: begin
            strobe = s_ds_rd;
            is_wr  = !s_rw_wr;
         end
         default: begin
            strobe = 1'b0;
            is_wr  = 1'b0;
         end
      endcase
   end

   assign act_o   = !s_cs_n && strobe;
   assign wr_o    = is_wr;
   assign addr_o  = mux_on ? mux_addr : s_addr;
   assign wdat_o  = s_dat;
   assign style_o = cur_style;

   // R2
   direct_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (act_o && style_o == BUS_DIRECT) |-> $past(!cs_n_i && !ds_rd_i));

endmodule

// File: rtl/cpu_port_ack.sv
module cpu_port_ack #(
   parameter int ACK_DLY = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic act_i,
   output logic rd_go_o,
   output logic commit_o,
   output logic ack_on_o,
   output logic ack_n_o,
   output logic ack_oe_o
);

   localparam int CW = $clog2(ACK_DLY + 1);
   localparam logic [CW-1:0] CNT_TOP = CW'(ACK_DLY);

   logic [CW-1:0] cnt;
   logic          ack_prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt      <= '0;
         ack_prev <= 1'b0;
      end else begin
         ack_prev <= ack_on_o;
         if (!act_i)
            cnt <= '0;
         else if (cnt != CNT_TOP)
            cnt <= cnt + 1'b1;
      end
   end

   assign ack_on_o = act_i && (cnt == CNT_TOP);
   assign commit_o = ack_on_o && !ack_prev;
   assign rd_go_o  = act_i && (cnt == '0);
   assign ack_n_o  = !ack_on_o;
   assign ack_oe_o = ack_on_o || ack_prev;

   // R8
   ack_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ack_n_o) |-> ($past(act_i) && $past(act_i, 2)));

   // R8
   ack_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ack_n_o && act_i) |=> (!ack_n_o || !act_i));

   // R9
   ack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ack_n_o) |-> ack_oe_o);

   // R9
   ack_park_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_oe_o && ack_n_o) |=> !ack_oe_o);

endmodule

// File: rtl/cpu_port_decode.sv
module cpu_port_decode
   import cpu_port_pkg::*;
#(
   parameter int AW          = 8,
   parameter int DW          = 16,
   parameter int FALIGN_ADDR = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW-1:0] addr_i,
   input  logic          wr_i,
   input  logic          act_i,
   input  logic          msel_i,
   input  logic          rd_go_i,
   input  logic          commit_i,
   input  logic          ack_on_i,
   input  logic [DW-1:0] wdat_i,
   input  logic [DW-1:0] reg_rdata_i,
   input  logic [DW-1:0] cm_rdata_i,
   input  logic [DW-1:0] dm_rdata_i,
   output logic          reg_wr_o,
   output logic          reg_rd_o,
   output logic          cm_wr_o,
   output logic          cm_rd_o,
   output logic          dm_rd_o,
   output logic [AW-2:0] acc_addr_o,
   output logic [DW-1:0] wdata_o,
   output logic [DW-1:0] dat_o,
   output logic          dat_oe_o
);

   localparam int LW = AW - 1;
   localparam logic [LW-1:0] FALIGN_LOC = LW'(FALIGN_ADDR);

   tgt_t tgt;
   logic ro;
   logic rd_fire, wr_fire;

   always_comb begin
      if (!addr_i[AW-1])
         tgt = TGT_REG;
      else if (msel_i)
         tgt = TGT_DATA;
      else
         tgt = TGT_CONN;
      ro = (tgt == TGT_DATA) ||
           ((tgt == TGT_REG) && (addr_i[LW-1:0] == FALIGN_LOC));
   end

   assign rd_fire = rd_go_i && !wr_i;
   assign wr_fire = commit_i && wr_i && !ro;

   assign reg_rd_o   = rd_fire && (tgt == TGT_REG);
   assign cm_rd_o    = rd_fire && (tgt == TGT_CONN);
   assign dm_rd_o    = rd_fire && (tgt == TGT_DATA);
   assign reg_wr_o   = wr_fire && (tgt == TGT_REG);
   assign cm_wr_o    = wr_fire && (tgt == TGT_CONN);
   assign acc_addr_o = addr_i[LW-1:0];
   assign wdata_o    = wdat_i;

   tgt_t          rd_src_q;
   logic          rd_dly;
   logic          rd_cyc_q;
   logic [DW-1:0] rdata_q;
   logic [DW-1:0] rsel;

   always_comb begin
      case (rd_src_q)
         TGT_REG:  rsel = reg_rdata_i;
         TGT_CONN: rsel = cm_rdata_i;
         TGT_DATA: rsel = dm_rdata_i;
         default:  rsel = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_src_q <= TGT_REG;
         rd_dly   <= 1'b0;
         rd_cyc_q <= 1'b0;
         rdata_q  <= '0;
      end else begin
         rd_dly <= rd_fire;
         if (rd_fire) begin
            rd_src_q <= tgt;
            rd_cyc_q <= 1'b1;
         end else if (!act_i) begin
            rd_cyc_q <= 1'b0;
         end
         if (rd_dly)
            rdata_q <= rsel;
      end
   end

   assign dat_o    = rdata_q;
   assign dat_oe_o = ack_on_i && rd_cyc_q;

   // R11
   strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({reg_wr_o, reg_rd_o, cm_wr_o, cm_rd_o, dm_rd_o}));

   // R11
   write_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr_o || cm_wr_o) |=> !(reg_wr_o || cm_wr_o));

   // R7
   ro_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reg_wr_o |-> (acc_addr_o != FALIGN_LOC));

   // R10
   no_write_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dat_oe_o |-> !(reg_wr_o || cm_wr_o));

endmodule

// File: rtl/cpu_port.sv
module cpu_port
   import cpu_port_pkg::*;
#(
   parameter int AW          = 8,
   parameter int DW          = 16,
   parameter int ACK_DLY     = 2,
   parameter int FALIGN_ADDR = 2,
   parameter bit HAS_MUX     = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          mux_mode_i,
   input  logic          cs_n_i,
   input  logic          ale_i,
   input  logic          ds_rd_i,
   input  logic          rw_wr_i,
   input  logic [AW-1:0] addr_i,
   input  logic [DW-1:0] dat_i,
   input  logic          msel_i,
   input  logic [DW-1:0] reg_rdata_i,
   input  logic [DW-1:0] cm_rdata_i,
   input  logic [DW-1:0] dm_rdata_i,
   output logic [DW-1:0] dat_o,
   output logic          dat_oe_o,
   output logic          ack_n_o,
   output logic          ack_oe_o,
   output logic          reg_wr_o,
   output logic          reg_rd_o,
   output logic          cm_wr_o,
   output logic          cm_rd_o,
   output logic          dm_rd_o,
   output logic [AW-2:0] acc_addr_o,
   output logic [DW-1:0] wdata_o
);

   generate
      if (ACK_DLY < 2) begin : g_bad_dly
         $error("ACK_DLY must leave room for the read return (>= 2)");
      end
      if (AW < 2) begin : g_bad_aw
         $error("AW must be at least 2");
      end
      if (HAS_MUX && (DW < AW)) begin : g_bad_dw
         $error("shared bus needs DW >= AW to carry the address");
      end
      if (FALIGN_ADDR >= (1 << (AW - 1))) begin : g_bad_fa
         $error("FALIGN_ADDR outside register space");
      end
   endgenerate

   logic          act;
   logic          is_wr;
   logic [AW-1:0] addr;
   logic [DW-1:0] wdat;
   bus_style_t    style;
   logic          rd_go, commit, ack_on;

   cpu_port_front #(
      .AW      (AW),
      .DW      (DW),
      .HAS_MUX (HAS_MUX)
   ) u_front (
      .clk        (clk),
      .rst_n      (rst_n),
      .mux_mode_i (mux_mode_i),
      .cs_n_i     (cs_n_i),
      .ale_i      (ale_i),
      .ds_rd_i    (ds_rd_i),
      .rw_wr_i    (rw_wr_i),
      .addr_i     (addr_i),
      .dat_i      (dat_i),
      .act_o      (act),
      .wr_o       (is_wr),
      .addr_o     (addr),
      .wdat_o     (wdat),
      .style_o    (style)
   );

   cpu_port_ack #(
      .ACK_DLY (ACK_DLY)
   ) u_ack (
      .clk      (clk),
      .rst_n    (rst_n),
      .act_i    (act),
      .rd_go_o  (rd_go),
      .commit_o (commit),
      .ack_on_o (ack_on),
      .ack_n_o  (ack_n_o),
      .ack_oe_o (ack_oe_o)
   );

   cpu_port_decode #(
      .AW          (AW),
      .DW          (DW),
      .FALIGN_ADDR (FALIGN_ADDR)
   ) u_decode (
      .clk         (clk),
      .rst_n       (rst_n),
      .addr_i      (addr),
      .wr_i        (is_wr),
      .act_i       (act),
      .msel_i      (msel_i),
      .rd_go_i     (rd_go),
      .commit_i    (commit),
      .ack_on_i    (ack_on),
      .wdat_i      (wdat),
      .reg_rdata_i (reg_rdata_i),
      .cm_rdata_i  (cm_rdata_i),
      .dm_rdata_i  (dm_rdata_i),
      .reg_wr_o    (reg_wr_o),
      .reg_rd_o    (reg_rd_o),
      .cm_wr_o     (cm_wr_o),
      .cm_rd_o     (cm_rd_o),
      .dm_rd_o     (dm_rd_o),
      .acc_addr_o  (acc_addr_o),
      .wdata_o     (wdata_o),
      .dat_o       (dat_o),
      .dat_oe_o    (dat_oe_o)
   );

   // R10
   read_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dat_oe_o |-> !ack_n_o);

   // R3
   style_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (act && $past(act)) |-> $stable(style) || !$past(mux_mode_i));

endmodule

// File: tb/sim_cpu_port.sv
`timescale 1ns/1ps
module sim_cpu_port;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        mux_mode = 1'b0, cs_n = 1'b1, ale = 1'b0, ds_rd = 1'b1, rw_wr = 1'b1;
   logic [7:0]  addr_in = '0;
   logic [15:0] dat_in = '0;
   logic        msel = 1'b0;
   logic [15:0] reg_rdata = '0, cm_rdata = '0, dm_rdata = '0;
   logic [15:0] dat_o, wdata;
   logic        dat_oe, ack_n, ack_oe;
   logic        reg_wr, reg_rd, cm_wr, cm_rd, dm_rd;
   logic [6:0]  acc_addr;

   int total = 0;
   int bad   = 0;

   always #4 clk = ~clk;

   cpu_port u0 (
      .clk(clk), .rst_n(rst_n), .mux_mode_i(mux_mode), .cs_n_i(cs_n),
      .ale_i(ale), .ds_rd_i(ds_rd), .rw_wr_i(rw_wr), .addr_i(addr_in),
      .dat_i(dat_in), .msel_i(msel), .reg_rdata_i(reg_rdata),
      .cm_rdata_i(cm_rdata), .dm_rdata_i(dm_rdata), .dat_o(dat_o),
      .dat_oe_o(dat_oe), .ack_n_o(ack_n), .ack_oe_o(ack_oe),
      .reg_wr_o(reg_wr), .reg_rd_o(reg_rd), .cm_wr_o(cm_wr),
      .cm_rd_o(cm_rd), .dm_rd_o(dm_rd), .acc_addr_o(acc_addr),
      .wdata_o(wdata)
   );

   // memory models: data valid the cycle after the read strobe
   function automatic logic [15:0] mkdat(input int src, input logic [6:0] a);
      return {2'(src), 7'h2B, a} ^ 16'h1C3A;
   endfunction

   always @(posedge clk) begin
      if (reg_rd) reg_rdata <= mkdat(0, acc_addr);
      if (cm_rd)  cm_rdata  <= mkdat(1, acc_addr);
      if (dm_rd)  dm_rdata  <= mkdat(2, acc_addr);
   end

   // strobe vector order {reg_wr, reg_rd, cm_wr, cm_rd, dm_rd}
   function automatic logic [4:0] rd_vec(input logic [7:0] a, input bit ms);
      if (!a[7]) return 5'b01000;
      return ms ? 5'b00001 : 5'b00010;
   endfunction

   function automatic logic [4:0] wr_vec(input logic [7:0] a, input bit ms);
      if (!a[7]) return (a[6:0] == 7'd2) ? 5'b00000 : 5'b10000;
      return ms ? 5'b00000 : 5'b00100;
   endfunction

   function automatic logic [15:0] exp_rdata(input logic [7:0] a, input bit ms);
      return mkdat(!a[7] ? 0 : (ms ? 2 : 1), a[6:0]);
   endfunction

   task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, got, exp, $time);
      end
   endtask

   // mode: 0 split bus, 1 shared bus separate strobes, 2 shared bus active-high strobe
   task automatic xfer(input int mode, input bit skip_ale, input logic [7:0] a,
                       input bit wr, input logic [15:0] d, input bit ms);
      logic [4:0] rv, wv, got;
      string tag;
      rv  = rd_vec(a, ms);
      wv  = wr_vec(a, ms);
      tag = (mode == 0) ? "R2" : ((mode == 1) ? "R3" : "R4");
      @(negedge clk);
      msel = ms;
      if (mode != 0) begin
         mux_mode = 1'b1;
         if (!skip_ale) begin
            cs_n = 1'b1; ale = 1'b1; dat_in = {8'h00, a};
            ds_rd = (mode == 1) ? 1'b0 : 1'b1; rw_wr = 1'b1;
            repeat (2) @(negedge clk);
         end
         ale = 1'b0; ds_rd = (mode == 1) ? 1'b1 : 1'b0; rw_wr = 1'b1;
         @(negedge clk);
         cs_n = 1'b0; dat_in = d;
         if (mode == 1) begin ds_rd = wr; rw_wr = !wr; end
         else begin ds_rd = 1'b1; rw_wr = !wr; end
      end else begin
         mux_mode = 1'b0; ale = 1'b0; addr_in = a; dat_in = d;
         cs_n = 1'b0; ds_rd = 1'b0; rw_wr = !wr;
      end
      for (int k = 1; k <= 4; k++) begin
         @(negedge clk);
         got = {reg_wr, reg_rd, cm_wr, cm_rd, dm_rd};
         chk("R11", 32'(got), 32'((k == 1 && !wr) ? rv : ((k == 3 && wr) ? wv : 5'b0)));
         if (k == 1 && !wr) chk(tag, 32'(acc_addr), 32'(a[6:0]));
         if (k == 2) chk("R8", 32'(ack_n), 32'd1);
         if (k == 3) begin
            chk("R8", 32'(ack_n), 32'd0);
            if (wr && wv != 5'b0) begin
               chk(tag, 32'(acc_addr), 32'(a[6:0]));
               chk("R11", 32'(wdata), 32'(d));
            end
            if (wr && wv == 5'b0) chk("R7", 32'({ack_oe, got}), 32'h20);
            if (!wr) begin
               chk("R10", 32'(dat_oe), 32'd1);
               chk(a[7] ? "R6" : "R5", 32'(dat_o), 32'(exp_rdata(a, ms)));
            end
         end
         if (k == 4) chk("R8", 32'(ack_n), 32'd0);
      end
   endtask

   task automatic release_bus(input bit ale_next, input logic [7:0] a_next, input int mode_next);
      cs_n = 1'b1; rw_wr = 1'b1; ds_rd = 1'b1;
      if (ale_next) begin
         ale = 1'b1; dat_in = {8'h00, a_next};
         ds_rd = (mode_next == 1) ? 1'b0 : 1'b1;
      end
      @(negedge clk);
      chk("R9", 32'({ack_n, ack_oe}), 32'b11);
      @(negedge clk);
      chk("R9", 32'(ack_oe), 32'd0);
      chk("R11", 32'({reg_wr, reg_rd, cm_wr, cm_rd, dm_rd}), 32'd0);
   endtask

   task automatic summary();
      $display("  test done: total=%0d bad=%0d", total, bad);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      total++; bad++;
      $display("FAIL R8 watchdog actual=hung expected=finished");
      summary();
      $finish;
   end

   initial begin
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1", 32'({ack_n, ack_oe, dat_oe}), 32'b100);
      chk("R1", 32'({reg_wr, reg_rd, cm_wr, cm_rd, dm_rd}), 32'd0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk("R1", 32'({ack_n, ack_oe}), 32'b10);

      // directed: each bus style, each space
      xfer(0, 1'b0, 8'h05, 1'b0, 16'h0, 1'b0); release_bus(1'b0, 8'h0, 0);
      xfer(0, 1'b0, 8'h91, 1'b1, 16'hBEEF, 1'b0); release_bus(1'b0, 8'h0, 0);
      xfer(1, 1'b0, 8'h8C, 1'b0, 16'h0, 1'b1); release_bus(1'b0, 8'h0, 0);
      xfer(1, 1'b0, 8'h07, 1'b1, 16'h1234, 1'b0); release_bus(1'b0, 8'h0, 0);
      xfer(2, 1'b0, 8'hA3, 1'b0, 16'h0, 1'b0); release_bus(1'b0, 8'h0, 0);
      xfer(2, 1'b0, 8'hC4, 1'b1, 16'h5678, 1'b0); release_bus(1'b0, 8'h0, 0);
      // R7 read-only targets
      xfer(0, 1'b0, 8'h02, 1'b1, 16'hAAAA, 1'b0); release_bus(1'b0, 8'h0, 0);
      xfer(2, 1'b0, 8'h85, 1'b1, 16'h5555, 1'b1); release_bus(1'b0, 8'h0, 0);
      // R3 latch edge in the same cycle as the previous release
      xfer(2, 1'b0, 8'h40, 1'b0, 16'h0, 1'b0); release_bus(1'b1, 8'h93, 1);
      xfer(1, 1'b1, 8'h93, 1'b0, 16'h0, 1'b0); release_bus(1'b1, 8'h11, 2);
      xfer(2, 1'b1, 8'h11, 1'b1, 16'h7E7E, 1'b0); release_bus(1'b0, 8'h0, 0);

      // random mix
      for (int n = 0; n < 80; n++) begin
         int          m;
         logic [7:0]  a;
         logic [15:0] d;
         bit          w, s;
         m = int'($urandom % 3);
         a = 8'($urandom);
         d = 16'($urandom);
         w = 1'($urandom);
         s = 1'($urandom);
         xfer(m, 1'b0, a, w, d, s);
         release_bus(1'b0, 8'h0, 0);
      end

      summary();
      $finish;
   end

endmodule